// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block takes one transmit frame descriptor and expands it into an ordered stream of buffer read requests. Each request names a 36-bit buffer address and a 12-bit byte length; together the buffers make up one outgoing frame. The descriptor is presented as a flat byte image on a wide input. A one-cycle start strobe begins a walk. The image must stay unchanged until the walk ends.

Requests leave on a valid/ready handshake, one entry per accepted transfer. The walker checks every descriptor before and while issuing it. It rejects an entry count of zero or one larger than the entry capacity. It rejects a single buffer longer than the per-buffer limit. It also rejects a running frame total that would pass the frame limit. When a descriptor is rejected, an error flag rises and no further requests follow. A clean walk ends with a one-cycle completion pulse.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset, busy, req_valid, done and err are all low.
- R2: The entry count is taken from bits 4:0 of byte 3 of the image (image bits 28:24). Bits 7:5 of that byte and bytes 0 to 2 have no effect on the walk.
- R3: A start with a count of 0 or above 20 sets err on the following edge. It issues no request and leaves busy low.
- R4: Entry i begins at byte 4+6*i. Its bytes 0 to 3 form address bits 31:0, least significant byte first. Its bytes 4 and 5 form a 16-bit little-endian field: field bits 3:0 are address bits 35:32, and field bits 15:4 are the buffer length.
- R5: Requests appear strictly in entry order, one entry per cycle with req_valid and req_ready both high. While req_ready is low, req_valid, req_addr and req_len hold steady.
- R6: done is high for exactly one cycle, the cycle after the last entry is accepted. busy falls on the same edge.
- R7: An entry whose length exceeds 4092 is never presented. err rises on the next edge, the walk stops, and done does not pulse.
- R8: If an entry's length would bring the running total of accepted lengths above 8192, that entry is never presented. err rises, the walk stops, and done does not pulse. A total of exactly 8192 is legal.
- R9: A start strobe while busy is ignored. A start accepted while idle clears err on its edge.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin walking the presented descriptor |
| desc | input | 992 | Descriptor byte image, byte k at bits 8k+7:8k |
| busy | output | 1 | Walk in progress |
| req_valid | output | 1 | A buffer request is presented |
| req_ready | input | 1 | Consumer accepts the presented request |
| req_addr | output | 36 | Buffer address |
| req_len | output | 12 | Buffer length in bytes |
| done | output | 1 | One-cycle pulse after a clean walk |
| err | output | 1 | Descriptor rejected; cleared by the next accepted start |

## Verification
The bench sweeps every value of the 5-bit count field. Small per-entry lengths keep the total limit out of play in this sweep, so it separates the accepted range 1 to 20 from the two rejected regions. Each count runs under continuous and under intermittent ready, which shows whether ordering and stall hold-off depend on back-pressure. Lengths at 4092 and 4093 bracket the per-buffer limit. Totals of exactly 8192 and 8193 bracket the frame limit. A junk-filled count byte and a mid-walk start strobe confirm which inputs the walker must ignore.

// File: rtl/sg_desc_walker.sv
module sg_desc_walker #(
  parameter int MAX_ENTRIES = 20,
  parameter int BUF_MAX     = 4092,
  parameter int FRAME_MAX   = 8192
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [8*(4+6*MAX_ENTRIES)-1:0]      desc,
  output logic                                busy,
  output logic                                req_valid,
  input  logic                                req_ready,
  output logic [35:0]                         req_addr,
  output logic [11:0]                         req_len,
  output logic                                done,
  output logic                                err
);
  localparam int HDR = 4;
  localparam int ESZ = 6;
  localparam int CW  = 5;
  localparam int IW  = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
  localparam int TW  = $clog2(FRAME_MAX + 4096);
  localparam logic [CW-1:0] CNT_MAX  = CW'(MAX_ENTRIES);
  localparam logic [11:0]   LEN_LIM  = 12'(BUF_MAX);
  localparam logic [TW-1:0] TOT_LIM  = TW'(FRAME_MAX);

  logic [35:0] ent_addr [MAX_ENTRIES];
  logic [11:0] ent_len  [MAX_ENTRIES];

  for (genvar i = 0; i < MAX_ENTRIES; i++) begin : g_ent
    logic [15:0] fld;
    assign fld         = desc[8*(HDR+ESZ*i)+32 +: 16];
    assign ent_addr[i] = {fld[3:0], desc[8*(HDR+ESZ*i) +: 32]};
    assign ent_len[i]  = fld[15:4];
  end

  logic [CW-1:0] cnt_in, cnt_r, idx;
  logic [TW-1:0] total, sum;
  logic          busy_r, done_r, err_r, bad, last;

  assign cnt_in   = desc[24 +: CW];
  assign req_addr = ent_addr[idx[IW-1:0]];
  assign req_len  = ent_len[idx[IW-1:0]];
  assign sum      = total + TW'(req_len);
  assign bad      = (req_len > LEN_LIM) || (sum > TOT_LIM);
  assign last     = (idx == cnt_r - CW'(1));

  assign busy      = busy_r;
  assign req_valid = busy_r && !bad;
  assign done      = done_r;
  assign err       = err_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      done_r <= 1'b0;
      err_r  <= 1'b0;
      cnt_r  <= '0;
      idx    <= '0;
      total  <= '0;
    end else begin
      done_r <= 1'b0;
      if (!busy_r) begin
        if (start) begin
          if (cnt_in == '0 || cnt_in > CNT_MAX) begin
            err_r <= 1'b1;
          end else begin
            err_r  <= 1'b0;
            busy_r <= 1'b1;
            cnt_r  <= cnt_in;
            idx    <= '0;
            total  <= '0;
          end
        end
      end else if (bad) begin
        err_r  <= 1'b1;
        busy_r <= 1'b0;
      end else if (req_ready) begin
        total <= sum;
        idx   <= idx + CW'(1);
        if (last) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end
endmodule

module sg_desc_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        req_valid,
  input logic        req_ready,
  input logic [35:0] req_addr,
  input logic [11:0] req_len,
  input logic        done,
  input logic        err
);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_len_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len <= 12'd4092));
  assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);
endmodule

bind sg_desc_walker sg_desc_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
  .done(done), .err(err)
);

// File: tb/sg_desc_walker_test.sv
module sg_desc_walker_test;
  localparam int PERIOD = 10;
  localparam int NE = 20;
  localparam int DW = 8*(4+6*NE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic req_ready = 1'b0;
  logic [DW-1:0] desc = '0;
  logic busy, req_valid, done, err;
  logic [35:0] req_addr;
  logic [11:0] req_len;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [35:0] e_addr [NE];
  logic [11:0] e_len  [NE];

  sg_desc_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .desc(desc), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .done(done), .err(err)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pack(input logic [7:0] cbyte);
    desc = '0;
    desc[23:0] = 24'hC3A51E;
    desc[31:24] = cbyte;
    for (int i = 0; i < NE; i++) begin
      desc[8*(4+6*i) +: 32] = e_addr[i][31:0];
      desc[8*(4+6*i)+32 +: 16] = {e_len[i], e_addr[i][35:32]};
    end
  endtask

  task automatic fill(input int seed, input int base_len, input int step);
    for (int i = 0; i < NE; i++) begin
      e_addr[i] = {4'(i + seed), 32'h9A000000 + 32'(i) * 32'h01030507 + 32'(seed)};
      e_len[i]  = 12'(base_len + i * step);
    end
  endtask

  task automatic walk(input int cnt, input int mode, input bit poke, input string tag);
    int exp_n = 0;
    bit exp_err = 0;
    int tot = 0;
    int n = 0;
    bit saw_done = 0;
    bit saw_err = 0;
    int k = 0;
    if (cnt == 0 || cnt > NE) exp_err = 1;
    else begin
      for (int i = 0; i < cnt; i++) begin
        if (e_len[i] > 4092 || tot + e_len[i] > 8192) begin exp_err = 1; break; end
        tot += e_len[i];
        exp_n++;
      end
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (k < 400) begin
      if (k > 0) @(negedge clk);
      req_ready = (mode == 0) ? 1'b1 : ((k % mode) != 0);
      start = (poke && k == 3) ? 1'b1 : 1'b0;
      if (k == 0) check(err == exp_err || !exp_err ? (exp_err ? 1'b1 : err == 1'b0) : 1'b1,
                        {"R9 err cleared ", tag}, err, 0);
      if (done) begin saw_done = 1; break; end
      if (err)  begin saw_err = 1; break; end
      if (req_valid && req_ready) begin
        if (n < NE)
          check(n < exp_n && req_addr == e_addr[n] && req_len == e_len[n],
                {"R5/R4 entry order ", tag}, {req_addr, req_len}, {e_addr[n], e_len[n]});
        n++;
      end
      k++;
    end
    start = 1'b0;
    req_ready = 1'b0;
    check(n == exp_n, {"R5 request count ", tag}, n, exp_n);
    check(saw_err == exp_err, {"R3/R7/R8 err ", tag}, saw_err, exp_err);
    check(saw_done == !exp_err, {"R6 done pulse ", tag}, saw_done, !exp_err);
    check(busy == 1'b0, {"R6 busy low at end ", tag}, busy, 0);
    @(negedge clk);
    check(done == 1'b0, {"R6 done single cycle ", tag}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && req_valid == 0 && done == 0 && err == 0, "R1 reset state",
          {busy, req_valid, done, err}, 0);
    rst_n = 1'b1;

    fill(1, 16, 8);
    for (int c = 0; c < 32; c++) begin
      pack(8'(c));
      walk(c, 0, 0, "sweep_full");
      walk(c, 3, 0, "sweep_stall");
    end

    fill(5, 100, 3);
    pack(8'hE3);
    walk(3, 2, 0, "R2 junk count bits");

    fill(2, 64, 0);
    e_len[2] = 12'd4093;
    pack(8'd6);
    walk(6, 0, 0, "R7 over buffer limit");
    e_len[2] = 12'd4092;
    pack(8'd6);
    walk(6, 2, 0, "R7 at buffer limit");

    fill(3, 0, 0);
    e_len[0] = 12'd4092; e_len[1] = 12'd4092; e_len[2] = 12'd8;
    pack(8'd3);
    walk(3, 0, 0, "R8 exact frame limit");
    e_len[2] = 12'd9;
    pack(8'd4);
    walk(4, 3, 0, "R8 over frame limit");

    fill(7, 40, 5);
    pack(8'd15);
    walk(15, 2, 1, "R9 start while busy");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule